// File: doc/BRIEF.md
# Beverage Dispenser Credit Controller

This block keeps the running credit of a two-product beverage dispenser and decides, every clock cycle, whether a customer event changes that credit, dispenses a product or refuses a bill. Its inputs are three single-cycle event pulses: a one-dollar bill has been inserted, a small cup has been requested, or a large cup has been requested. Its outputs are single-cycle commands for the dispensing and change mechanisms, which sit outside the block. It also reports the number of quarters of change that go with each sale.

Credit is held internally as a count of quarters. Payment comes only as whole-dollar bills. Credit never exceeds two dollars. The small cup costs one dollar and the large cup costs one dollar and twenty-five cents. A control state machine has three states: empty, holding part of the cap, and full. It sends a small strobe struct to a datapath, which holds the credit, works out the change and registers every output.

Top module: `coffee_credit_ctrl`

## Requirements
- R1: A bill pulse while credit is below the cap adds four quarters to `creditQuarters`, visible one clock after the pulse. The sequence from empty is 0, then 4, then 8.
- R2: `creditQuarters` never exceeds 8. A bill pulse while credit is 8 raises `ejectBill` for one cycle and leaves the credit at 8.
- R3: A small request with at least 4 quarters of credit raises `serveSmall` for one cycle and clears the credit to 0. `changeQuarters` equals the credit minus 4, which is 0 from one dollar and 4 from two dollars.
- R4: A large request with at least 5 quarters of credit raises `serveLarge` for one cycle, drives `changeQuarters` to 3 (from two dollars) and clears the credit.
- R5: A request the credit cannot pay for produces no pulse and leaves the credit unchanged. This covers a large request with one dollar, and any request with zero credit.
- R6: When several events arrive together, only the highest one is acted on: the bill first, then the large request, then the small request. The others are dropped, even when the chosen event is itself refused or ignored.
- R7: All outputs are registered and respond one clock after the event. Each command pulse lasts one cycle, and at most one of `serveSmall`, `serveLarge` and `ejectBill` is high in any cycle.
- R8: A synchronous active-high `rst` clears the credit to 0 and drives every output low at the next clock, whatever the other inputs are.
- R9: `changeQuarters` is 0 in every cycle without a serve pulse, including cycles with an eject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| billIn | input | 1 | One-cycle pulse: a dollar bill was inserted |
| reqSmall | input | 1 | One-cycle pulse: small cup requested |
| reqLarge | input | 1 | One-cycle pulse: large cup requested |
| serveSmall | output | 1 | One-cycle command to dispense a small cup |
| serveLarge | output | 1 | One-cycle command to dispense a large cup |
| ejectBill | output | 1 | One-cycle command to give back a refused bill |
| changeQuarters | output | 3 | Quarters to return, valid with a serve pulse |
| creditQuarters | output | 4 | Current credit in quarters |

## Verification
A control state that disagrees with the credit register shows up one clock after the next event. A bill at the cap gets absorbed instead of ejected, or a bill below the cap gets ejected. A stale credit after a sale shows up at once on `creditQuarters`, and a wrong subtraction shows up in `changeQuarters` in the same cycle as the serve pulse. Because the bench compares every output on every clock against its own credit model, a fault is reported within one cycle of the first event that exposes it. Random event bursts reach the combined-event and refusal paths from every credit level.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY   = 2'd0,
    ST_HOLDING = 2'd1,
    ST_FULL    = 2'd2
  } vendState_t;

  typedef struct packed {
    logic addBill;
    logic doSmall;
    logic doLarge;
    logic refuse;
  } vendStrobe_t;

endpackage

// File: rtl/vend_control.sv
module vend_control
  import vend_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        billIn,
  input  logic        reqSmall,
  input  logic        reqLarge,
  input  logic        fullAfterAdd,
  input  logic        affordSmall,
  input  logic        affordLarge,
  output vendStrobe_t strobe
);

  vendState_t stateQ, stateD;

  // Event selection: bill beats large, large beats small; losers dropped.
  always_comb begin
    strobe = '0;
    stateD = stateQ;
    if (billIn) begin
      if (stateQ == ST_FULL) begin
        strobe.refuse = 1'b1;
      end else begin
        strobe.addBill = 1'b1;
        stateD = fullAfterAdd ? ST_FULL : ST_HOLDING;
      end
    end else if (reqLarge) begin
      if (stateQ != ST_EMPTY && affordLarge) begin
        strobe.doLarge = 1'b1;
        stateD = ST_EMPTY;
      end
    end else if (reqSmall) begin
      if (stateQ != ST_EMPTY && affordSmall) begin
        strobe.doSmall = 1'b1;
        stateD = ST_EMPTY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_EMPTY;
    else     stateQ <= stateD;
  end

endmodule

// File: rtl/vend_datapath.sv
module vend_datapath
  import vend_pkg::*;
#(
  parameter int BILL_QUARTERS  = 4,
  parameter int MAX_QUARTERS   = 8,
  parameter int SMALL_QUARTERS = 4,
  parameter int LARGE_QUARTERS = 5,
  parameter int CREDIT_W       = 4,
  parameter int CHANGE_W       = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  vendStrobe_t         strobe,
  output logic                fullAfterAdd,
  output logic                affordSmall,
  output logic                affordLarge,
  output logic                serveSmall,
  output logic                serveLarge,
  output logic                ejectBill,
  output logic [CHANGE_W-1:0] changeQuarters,
  output logic [CREDIT_W-1:0] creditQuarters
);

  localparam int WIDE_W = CREDIT_W + 2;

  logic [CREDIT_W-1:0] creditQ;
  logic [WIDE_W-1:0]   twoAhead;

  assign twoAhead     = WIDE_W'(creditQ) + WIDE_W'(2 * BILL_QUARTERS);
  assign fullAfterAdd = twoAhead > WIDE_W'(MAX_QUARTERS);
  assign affordSmall  = creditQ >= CREDIT_W'(SMALL_QUARTERS);
  assign affordLarge  = creditQ >= CREDIT_W'(LARGE_QUARTERS);

  always_ff @(posedge clk) begin
    if (rst) begin
      creditQ        <= '0;
      serveSmall     <= 1'b0;
      serveLarge     <= 1'b0;
      ejectBill      <= 1'b0;
      changeQuarters <= '0;
    end else begin
      serveSmall     <= strobe.doSmall;
      serveLarge     <= strobe.doLarge;
      ejectBill      <= strobe.refuse;
      changeQuarters <= '0;
      if (strobe.addBill) begin
        creditQ <= creditQ + CREDIT_W'(BILL_QUARTERS);
      end else if (strobe.doLarge) begin
        creditQ        <= '0;
        changeQuarters <= CHANGE_W'(creditQ - CREDIT_W'(LARGE_QUARTERS));
      end else if (strobe.doSmall) begin
        creditQ        <= '0;
        changeQuarters <= CHANGE_W'(creditQ - CREDIT_W'(SMALL_QUARTERS));
      end
    end
  end

  assign creditQuarters = creditQ;

endmodule

// File: rtl/coffee_credit_ctrl.sv
module coffee_credit_ctrl
  import vend_pkg::*;
#(
  parameter int BILL_QUARTERS  = 4,
  parameter int MAX_QUARTERS   = 8,
  parameter int SMALL_QUARTERS = 4,
  parameter int LARGE_QUARTERS = 5,
  parameter int CREDIT_W       = $clog2(MAX_QUARTERS + 1),
  parameter int CHANGE_W       = $clog2(MAX_QUARTERS - SMALL_QUARTERS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                billIn,
  input  logic                reqSmall,
  input  logic                reqLarge,
  output logic                serveSmall,
  output logic                serveLarge,
  output logic                ejectBill,
  output logic [CHANGE_W-1:0] changeQuarters,
  output logic [CREDIT_W-1:0] creditQuarters
);

  vendStrobe_t strobe;
  logic fullAfterAdd, affordSmall, affordLarge;

  vend_control u_control (
    .clk          (clk),
    .rst          (rst),
    .billIn       (billIn),
    .reqSmall     (reqSmall),
    .reqLarge     (reqLarge),
    .fullAfterAdd (fullAfterAdd),
    .affordSmall  (affordSmall),
    .affordLarge  (affordLarge),
    .strobe       (strobe)
  );

  vend_datapath #(
    .BILL_QUARTERS  (BILL_QUARTERS),
    .MAX_QUARTERS   (MAX_QUARTERS),
    .SMALL_QUARTERS (SMALL_QUARTERS),
    .LARGE_QUARTERS (LARGE_QUARTERS),
    .CREDIT_W       (CREDIT_W),
    .CHANGE_W       (CHANGE_W)
  ) u_datapath (
    .clk            (clk),
    .rst            (rst),
    .strobe         (strobe),
    .fullAfterAdd   (fullAfterAdd),
    .affordSmall    (affordSmall),
    .affordLarge    (affordLarge),
    .serveSmall     (serveSmall),
    .serveLarge     (serveLarge),
    .ejectBill      (ejectBill),
    .changeQuarters (changeQuarters),
    .creditQuarters (creditQuarters)
  );

endmodule

// File: rtl/coffee_credit_checker.sv
module coffee_credit_checker #(
  parameter int MAX_QUARTERS   = 8,
  parameter int LARGE_QUARTERS = 5,
  parameter int CREDIT_W       = 4,
  parameter int CHANGE_W       = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                serveSmall,
  input logic                serveLarge,
  input logic                ejectBill,
  input logic [CHANGE_W-1:0] changeQuarters,
  input logic [CREDIT_W-1:0] creditQuarters
);

  a_r2_credit_cap: assert property (@(posedge clk) disable iff (rst)
    int'(creditQuarters) <= MAX_QUARTERS);

  a_r2_eject_holds_credit: assert property (@(posedge clk) disable iff (rst)
    ejectBill |-> creditQuarters == $past(creditQuarters));

  a_r3_sale_clears_credit: assert property (@(posedge clk) disable iff (rst)
    (serveSmall || serveLarge) |-> creditQuarters == '0);

  a_r4_large_change: assert property (@(posedge clk) disable iff (rst)
    serveLarge |-> int'(changeQuarters) == int'($past(creditQuarters)) - LARGE_QUARTERS);

  a_r7_one_command: assert property (@(posedge clk) disable iff (rst)
    $onehot0({serveSmall, serveLarge, ejectBill}));

  a_r7_small_single: assert property (@(posedge clk) disable iff (rst)
    serveSmall |=> !serveSmall);

  a_r7_large_single: assert property (@(posedge clk) disable iff (rst)
    serveLarge |=> !serveLarge);

  a_r9_change_with_sale: assert property (@(posedge clk) disable iff (rst)
    (changeQuarters != '0) |-> (serveSmall || serveLarge));

endmodule

bind coffee_credit_ctrl coffee_credit_checker #(
  .MAX_QUARTERS   (MAX_QUARTERS),
  .LARGE_QUARTERS (LARGE_QUARTERS),
  .CREDIT_W       (CREDIT_W),
  .CHANGE_W       (CHANGE_W)
) u_checker (
  .clk            (clk),
  .rst            (rst),
  .serveSmall     (serveSmall),
  .serveLarge     (serveLarge),
  .ejectBill      (ejectBill),
  .changeQuarters (changeQuarters),
  .creditQuarters (creditQuarters)
);

// File: tb/coffee_credit_ctrl_test.sv
module coffee_credit_ctrl_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, billIn, reqSmall, reqLarge;
  logic serveSmall, serveLarge, ejectBill;
  logic [2:0] changeQuarters;
  logic [3:0] creditQuarters;

  coffee_credit_ctrl uut (
    .clk(clk), .rst(rst), .billIn(billIn), .reqSmall(reqSmall), .reqLarge(reqLarge),
    .serveSmall(serveSmall), .serveLarge(serveLarge), .ejectBill(ejectBill),
    .changeQuarters(changeQuarters), .creditQuarters(creditQuarters)
  );

  int compared = 0;
  int mismatched = 0;
  int modelCredit = 0;
  bit finished = 0;

  task automatic cmp(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Apply one cycle of events, advance the reference model, compare after the edge.
  task automatic step(bit r, bit b, bit s, bit l, string tag);
    int expS = 0, expL = 0, expE = 0, expC = 0;
    rst = r; billIn = b; reqSmall = s; reqLarge = l;
    if (r) begin
      modelCredit = 0;
    end else if (b) begin
      if (modelCredit + 4 <= 8) modelCredit += 4;
      else expE = 1;
    end else if (l) begin
      if (modelCredit >= 5) begin expL = 1; expC = modelCredit - 5; modelCredit = 0; end
    end else if (s) begin
      if (modelCredit >= 4) begin expS = 1; expC = modelCredit - 4; modelCredit = 0; end
    end
    @(posedge clk);
    #2;
    cmp(tag, "serveSmall", int'(serveSmall), expS);
    cmp(tag, "serveLarge", int'(serveLarge), expL);
    cmp(tag, "ejectBill", int'(ejectBill), expE);
    cmp(tag, "changeQuarters", int'(changeQuarters), expC);
    cmp(tag, "creditQuarters", int'(creditQuarters), modelCredit);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; billIn = 1'b0; reqSmall = 1'b0; reqLarge = 1'b0;
    #2;
    step(1, 0, 0, 0, "R8");
    step(1, 1, 1, 1, "R8");
    // R5: requests with zero credit
    step(0, 0, 0, 1, "R5");
    step(0, 0, 1, 0, "R5");
    // R1: credit climbs 0 -> 4 -> 8
    step(0, 1, 0, 0, "R1");
    step(0, 1, 0, 0, "R1");
    // R2: bills at the cap are ejected; R9 no change on eject
    step(0, 1, 0, 0, "R2");
    step(0, 1, 0, 0, "R9");
    // R4: large from two dollars, then idle cycle (R7)
    step(0, 0, 0, 1, "R4");
    step(0, 0, 0, 0, "R7");
    // R5: large with one dollar ignored, credit kept
    step(0, 1, 0, 0, "R1");
    step(0, 0, 0, 1, "R5");
    // R3: small from one dollar, change 0
    step(0, 0, 1, 0, "R3");
    step(0, 0, 0, 0, "R7");
    // R3: small from two dollars, change 4
    step(0, 1, 0, 0, "R1");
    step(0, 1, 0, 0, "R1");
    step(0, 0, 1, 0, "R3");
    // R6: priority cases
    step(0, 1, 0, 0, "R1");
    step(0, 1, 0, 1, "R6");   // bill beats large: credit 8
    step(0, 1, 1, 0, "R6");   // bill at cap: eject, small dropped
    step(0, 0, 1, 1, "R6");   // large beats small from 8
    step(0, 1, 0, 0, "R1");
    step(0, 0, 1, 1, "R6");   // large ignored at 4, small dropped
    // R8: reset with credit held and bill pending
    step(0, 1, 0, 0, "R1");
    step(1, 1, 0, 0, "R8");
    step(0, 0, 0, 0, "R8");
    // R7: random event bursts from every credit level
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 63);
      step(r == 0, $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
           $urandom_range(0, 2) == 0, "R7");
    end
    step(0, 0, 0, 0, "R7");
    finished = 1;
    summary();
    $finish;
  end

endmodule